// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block produces the bit-level timebase of a CAN node from the system clock. A programmable divider turns the system clock into time-quantum (tq) ticks. A segment sequencer advances once per tick and walks each bit through three regions: a one-quantum synchronization slot, a first timing region that covers propagation plus phase 1, and a second timing region for phase 2. At the end of the first region it pulses a sample strobe and presents the bus level it captured. At the end of the second region it pulses a transmit strobe, so the frame logic can drive the next bit with no processing delay after the sample point.

The receive line passes through a two-flop synchronizer. The block watches it for recessive-to-dominant transitions at tq resolution. A mode input set by the protocol logic chooses what such an edge does. In hard mode the edge restarts the bit. In resynchronization mode it stretches or trims the current bit by the measured phase error, limited to the jump width. Every timing field is programmed as its length minus one.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts ({cfg_brpe, cfg_brpe's lower neighbour cfg_brp} + 1) system clocks. cfg_brpe forms bits 9..6 and cfg_brp forms bits 5..0 of the 10-bit divide value. The sequencer moves only on quantum ticks.
- R2: With no bus edge, sample_stb pulses for one clock once every (cfg_tseg1 + cfg_tseg2 + 3) quanta.
- R3: sample_stb follows tx_stb by (cfg_tseg1 + 2) quanta, and tx_stb follows sample_stb by (cfg_tseg2 + 1) quanta. The two strobes never coincide.
- R4: sample_bit is the receive level after a two-flop synchronizer, as seen at the sample point (1 = recessive). It changes only together with sample_stb.
- R5: In resync mode (sync_hard = 0), a falling edge seen in the first timing region at quantum index c lengthens that region by min(c + 1, cfg_sjw + 1) quanta.
- R6: In resync mode, a falling edge seen at quantum index c of the second timing region has error e = cfg_tseg2 + 1 - c. If e <= cfg_sjw + 1, that quantum becomes the sync slot of a new bit. Otherwise the region is shortened by cfg_sjw + 1 quanta.
- R7: At most one resynchronization is applied per bit. Later falling edges in the same bit have no effect.
- R8: Dominant-to-recessive (rising) edges never alter the timing.
- R9: In hard mode (sync_hard = 1), a falling edge makes the quantum in which it is seen the sync slot. The next quantum is the first of the first timing region, whatever the jump width, and tx_stb pulses.
- R10: While reset is held, sample_stb and tx_stb are 0 and sample_bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_brp | input | 6 | Divider low bits, value minus one |
| cfg_brpe | input | 4 | Divider extension, upper bits |
| cfg_tseg1 | input | 4 | Propagation plus phase 1 length minus one |
| cfg_tseg2 | input | 3 | Phase 2 length minus one |
| cfg_sjw | input | 2 | Jump width minus one |
| sync_hard | input | 1 | 1 = hard synchronization, 0 = resynchronization |
| rx_raw | input | 1 | Unsynchronized bus receive line |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Bus level captured at the sample point |
| tx_stb | output | 1 | One-clock pulse at the start of each bit |

## Verification
A wrong segment counter or a bad length register appears as a strobe interval that differs from the nominal bit length. The error shows at the very next sample_stb, which is at most one bit time away. A faulty phase-error or jump-width calculation moves that next sample strobe by a predictable number of quanta. A missing one-resync guard only shows when a second edge lands in the same bit, so stimulus places two edges inside the first timing region. A bad synchronizer or edge filter shows up as a wrong sample_bit, or as a timing shift after a rising edge, within one bit.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_ONE  = 2'd1,
    SEG_TWO  = 2'd2
  } can_seg_e;
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tq_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tq_tick = (cnt_q == div_m1);
    cnt_d   = tq_tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_bt_rxsync.sv
module can_bt_rxsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_tick,
  input  logic rx_raw,
  output logic rx_lvl,
  output logic fall_edge
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= rx_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], rx_raw};
      end
    end
  endgenerate

  assign rx_lvl    = sh_q[STAGES-1];
  assign fall_edge = last_q & ~rx_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= 1'b1;
    else if (tq_tick) last_q <= rx_lvl;
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             fall_edge,
  input  logic             rx_lvl,
  input  logic             sync_hard,
  input  logic [TS1_W-1:0] tseg1,
  input  logic [TS2_W-1:0] tseg2,
  input  logic [SJW_W-1:0] sjw,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             tx_stb
);
  localparam int CNT_W = ((TS1_W > TS2_W) ? TS1_W : TS2_W) + 2;
  typedef logic [CNT_W-1:0] cnt_t;

  can_seg_e seg_q, seg_d;
  cnt_t     cnt_q, cnt_d, ext_q, ext_d, shr_q, shr_d;
  logic     rs_q, rs_d, smp_d, tx_d, bit_q, bit_d, smp_q, tx_q;
  cnt_t     ts1_f, ts2_f, sjw_f, len1, len2, e_late, e_early;
  logic     resync;

  function automatic cnt_t cap(input cnt_t a, input cnt_t b);
    return (a < b) ? a : b;
  endfunction

  always_comb begin
    seg_d   = seg_q;
    cnt_d   = cnt_q;
    ext_d   = ext_q;
    shr_d   = shr_q;
    rs_d    = rs_q;
    smp_d   = 1'b0;
    tx_d    = 1'b0;
    bit_d   = bit_q;
    ts1_f   = cnt_t'(tseg1) + 1'b1;
    ts2_f   = cnt_t'(tseg2) + 1'b1;
    sjw_f   = cnt_t'(sjw) + 1'b1;
    e_late  = cnt_q + 1'b1;
    e_early = ts2_f - cnt_q;
    len1    = ts1_f + ext_q;
    len2    = ts2_f - shr_q;
    resync  = fall_edge && !sync_hard && !rs_q;
    if (tq_tick) begin
      if (fall_edge && sync_hard) begin
        seg_d = SEG_ONE;
        cnt_d = '0;
        ext_d = '0;
        shr_d = '0;
        rs_d  = 1'b0;
        tx_d  = 1'b1;
      end else begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_d = SEG_ONE;
            cnt_d = '0;
          end
          SEG_ONE: begin
            if (resync) begin
              ext_d = cap(e_late, sjw_f);
              rs_d  = 1'b1;
              len1  = ts1_f + ext_d;
            end
            if (cnt_q == len1 - 1'b1) begin
              seg_d = SEG_TWO;
              cnt_d = '0;
              smp_d = 1'b1;
              bit_d = rx_lvl;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: begin
            if (resync && (e_early <= sjw_f)) begin
              seg_d = SEG_ONE;
              cnt_d = '0;
              ext_d = '0;
              shr_d = '0;
              rs_d  = 1'b0;
              tx_d  = 1'b1;
            end else begin
              if (resync) begin
                shr_d = sjw_f;
                rs_d  = 1'b1;
                len2  = ts2_f - sjw_f;
              end
              if (cnt_q == len2 - 1'b1) begin
                seg_d = SEG_SYNC;
                cnt_d = '0;
                ext_d = '0;
                shr_d = '0;
                rs_d  = 1'b0;
                tx_d  = 1'b1;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
      ext_q <= '0;
      shr_q <= '0;
      rs_q  <= 1'b0;
      smp_q <= 1'b0;
      tx_q  <= 1'b0;
      bit_q <= 1'b1;
    end else begin
      seg_q <= seg_d;
      cnt_q <= cnt_d;
      ext_q <= ext_d;
      shr_q <= shr_d;
      rs_q  <= rs_d;
      smp_q <= smp_d;
      tx_q  <= tx_d;
      bit_q <= bit_d;
    end
  end

  assign sample_stb = smp_q;
  assign sample_bit = bit_q;
  assign tx_stb     = tx_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W  = 6,
  parameter int BRPE_W = 4,
  parameter int TS1_W  = 4,
  parameter int TS2_W  = 3,
  parameter int SJW_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BRP_W-1:0]  cfg_brp,
  input  logic [BRPE_W-1:0] cfg_brpe,
  input  logic [TS1_W-1:0]  cfg_tseg1,
  input  logic [TS2_W-1:0]  cfg_tseg2,
  input  logic [SJW_W-1:0]  cfg_sjw,
  input  logic              sync_hard,
  input  logic              rx_raw,
  output logic              sample_stb,
  output logic              sample_bit,
  output logic              tx_stb
);
  localparam int DIV_W = BRP_W + BRPE_W;

  logic [DIV_W-1:0] div_m1;
  logic             tq_tick;
  logic             rx_lvl;
  logic             fall_edge;

  assign div_m1 = {cfg_brpe, cfg_brp};

  can_bt_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_m1  (div_m1),
    .tq_tick (tq_tick)
  );

  can_bt_rxsync #(.STAGES(SYNC_N)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tq_tick   (tq_tick),
    .rx_raw    (rx_raw),
    .rx_lvl    (rx_lvl),
    .fall_edge (fall_edge)
  );

  can_bt_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tq_tick    (tq_tick),
    .fall_edge  (fall_edge),
    .rx_lvl     (rx_lvl),
    .sync_hard  (sync_hard),
    .tseg1      (cfg_tseg1),
    .tseg2      (cfg_tseg2),
    .sjw        (cfg_sjw),
    .sample_stb (sample_stb),
    .sample_bit (sample_bit),
    .tx_stb     (tx_stb)
  );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic tq_tick,
  input logic fall_edge,
  input logic sync_hard,
  input logic sample_stb,
  input logic sample_bit,
  input logic tx_stb
);
  p_one_clock_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  p_one_clock_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |=> !tx_stb);

  p_strobes_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && tx_stb));

  p_sample_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(tq_tick));

  p_tx_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> $past(tq_tick));

  p_bit_moves_at_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_bit) |-> sample_stb);

  p_hard_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && fall_edge && sync_hard) |=> tx_stb);
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tq_tick    (tq_tick),
  .fall_edge  (fall_edge),
  .sync_hard  (sync_hard),
  .sample_stb (sample_stb),
  .sample_bit (sample_bit),
  .tx_stb     (tx_stb)
);

// File: tb/test_can_bit_timer.sv
`timescale 1ns/1ps
module test_can_bit_timer;
  localparam time TCLK = 20ns;

  logic       clk;
  logic       rst_n;
  logic [5:0] cfg_brp;
  logic [3:0] cfg_brpe;
  logic [3:0] cfg_tseg1;
  logic [2:0] cfg_tseg2;
  logic [1:0] cfg_sjw;
  logic       sync_hard;
  logic       rx_raw;
  logic       sample_stb;
  logic       sample_bit;
  logic       tx_stb;

  int errors = 0;
  int checks = 0;
  int   exp_int_q[$];
  logic exp_bit_q[$];
  string exp_tag_q[$];
  time  last_s = 0;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_brpe(cfg_brpe),
    .cfg_tseg1(cfg_tseg1), .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw),
    .sync_hard(sync_hard), .rx_raw(rx_raw), .sample_stb(sample_stb),
    .sample_bit(sample_bit), .tx_stb(tx_stb)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected interval and level at every sample strobe
  always @(negedge clk) begin
    if (rst_n && sample_stb === 1'b1) begin
      if (exp_int_q.size() > 0) begin
        int   ei;
        logic eb;
        string tg;
        int   act;
        ei  = exp_int_q.pop_front();
        eb  = exp_bit_q.pop_front();
        tg  = exp_tag_q.pop_front();
        act = int'(($time - last_s) / TCLK);
        check(act == ei, {tg, " interval"}, act, ei);
        check(sample_bit === eb, {tg, " sample_bit"}, int'(sample_bit), int'(eb));
      end
      last_s = $time;
    end
  end

  task automatic push(input int ei, input logic eb, input string tg);
    exp_int_q.push_back(ei);
    exp_bit_q.push_back(eb);
    exp_tag_q.push_back(tg);
  endtask

  task automatic wait_stb();
    do @(negedge clk); while (sample_stb !== 1'b1);
  endtask

  task automatic wait_tx();
    do @(negedge clk); while (tx_stb !== 1'b1);
  endtask

  task automatic drain();
    while (exp_int_q.size() > 0) @(negedge clk);
  endtask

  task automatic restart(input logic [3:0] be, input logic [5:0] bp, input logic [3:0] t1,
                         input logic [2:0] t2, input logic [1:0] sj, input logic hd);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_brpe = be; cfg_brp = bp; cfg_tseg1 = t1; cfg_tseg2 = t2;
    cfg_sjw = sj; sync_hard = hd; rx_raw = 1'b1;
    repeat (3) @(negedge clk);
    check(sample_stb === 1'b0, "R10 sample_stb in reset", int'(sample_stb), 0);
    check(tx_stb === 1'b0, "R10 tx_stb in reset", int'(tx_stb), 0);
    check(sample_bit === 1'b1, "R10 sample_bit in reset", int'(sample_bit), 1);
    rst_n = 1'b1;
  endtask

  task automatic plain_bits(input int n, input int ei, input logic eb, input string tg);
    for (int i = 0; i < n; i++) begin
      wait_stb();
      @(posedge clk);
      push(ei, eb, tg);
    end
    drain();
  endtask

  // level change at the negedge just before edge k after the reference sample point
  task automatic edge_bit(input int k, input logic lvl, input int ei, input logic eb, input string tg);
    wait_stb();
    if (k == 1) rx_raw = lvl;
    @(posedge clk);
    push(ei, eb, tg);
    if (k > 1) begin
      repeat (k - 1) @(negedge clk);
      rx_raw = lvl;
    end
  endtask

  task automatic check_off(input int ea, input int eb, input string tg);
    time t0, t1, t2;
    wait_tx();    t0 = $time;
    wait_stb();   t1 = $time;
    wait_tx();    t2 = $time;
    check(int'((t1 - t0) / TCLK) == ea, {tg, " tx to sample"}, int'((t1 - t0) / TCLK), ea);
    check(int'((t2 - t1) / TCLK) == eb, {tg, " sample to tx"}, int'((t2 - t1) / TCLK), eb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_raw = 1'b1; sync_hard = 1'b0;
    cfg_brp = '0; cfg_brpe = '0; cfg_tseg1 = '0; cfg_tseg2 = '0; cfg_sjw = '0;

    // 1 tq = 1 clock, seg1 = 4, seg2 = 4, bit = 9, jump width 2
    restart(4'd0, 6'd0, 4'd3, 3'd2 + 3'd1, 2'd1, 1'b0);
    plain_bits(3, 9, 1'b1, "R2 nominal bit");
    check_off(5, 4, "R3 offsets");
    edge_bit(1, 1'b0, 7, 1'b0, "R6 early edge within jump width");
    edge_bit(3, 1'b1, 9, 1'b1, "R8 rising edge in sync slot");
    edge_bit(6, 1'b0, 11, 1'b0, "R5 late edge capped");
    edge_bit(6, 1'b1, 9, 1'b1, "R8 rising edge in first region");
    drain();

    // jump width 1
    restart(4'd0, 6'd0, 4'd3, 3'd3, 2'd0, 1'b0);
    edge_bit(1, 1'b0, 8, 1'b0, "R6 early edge beyond jump width");
    edge_bit(6, 1'b1, 9, 1'b1, "R8 rising edge");
    edge_bit(6, 1'b0, 10, 1'b0, "R5 late edge limit 1");
    edge_bit(6, 1'b1, 9, 1'b1, "R4 level back to recessive");
    drain();

    // jump width 4, two falling edges in one bit
    restart(4'd0, 6'd0, 4'd3, 3'd3, 2'd3, 1'b0);
    wait_stb();
    @(posedge clk);
    push(12, 1'b0, "R7 second edge ignored");
    repeat (5) @(negedge clk); rx_raw = 1'b0;
    @(negedge clk);            rx_raw = 1'b1;
    @(negedge clk);            rx_raw = 1'b0;
    edge_bit(6, 1'b1, 9, 1'b1, "R8 rising after double edge");
    drain();

    // hard synchronization, jump width 1
    restart(4'd0, 6'd0, 4'd3, 3'd3, 2'd0, 1'b1);
    edge_bit(6, 1'b0, 12, 1'b0, "R9 hard restart");
    edge_bit(6, 1'b1, 9, 1'b1, "R9 rising edge no restart");
    drain();

    // divider 3, seg1 = 6, seg2 = 2
    restart(4'd0, 6'd2, 4'd5, 3'd1, 2'd1, 1'b0);
    plain_bits(2, 27, 1'b1, "R1 divide by 3");
    check_off(21, 6, "R3 offsets divided");

    // extension field: divide value 64 + 1
    restart(4'd1, 6'd0, 4'd0, 3'd0, 2'd0, 1'b0);
    plain_bits(2, 195, 1'b1, "R1 extension bits");
    check_off(130, 65, "R3 shortest bit");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule